// File: doc/BRIEF.md
# Receiver Detect Termination Controller

This block runs one lane of a repeater input. It decides whether the input shows a high impedance or a 50-ohm termination to the line. A 2-bit mode field selects one of four behaviours. Two of them are fixed: the input is held at high impedance (detection is then done by hand), or it is terminated at all times. The other two are automatic. They fire a one-cycle far-end detection request toward an analog comparator at a fixed poll interval. They keep the input at high impedance until the comparator reports a receiver, then latch termination. One automatic variant stops after a bounded number of attempts. The other keeps polling until a receiver is found.

A power-down pin always disables the output drivers and removes the termination. If power-down stays high for at least a minimum width and is then released, the latched state is cleared and polling starts over. A shorter pulse only blanks the outputs for its duration. Every timing in the block derives from a cycles-per-microsecond parameter: the poll interval (12 ms nominal), the attempt limit (50 polls, so a 600 ms window) and the power-down width (5 us).

Top module: `rxdet_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `det_req_o` and `term_en_o` are 0 and `drv_en_o` equals the inverse of `pdn_i`.
- R2: With mode 2'b00 (manual, high impedance) no detect request is ever issued and `term_en_o` stays 0, whatever the value of `det_i`.
- R3: With mode 2'b11 (manual, terminated) `term_en_o` becomes 1 at the second clock edge after the mode is applied and no detect request is issued.
- R4: In mode 2'b01 or 2'b10, the first `det_req_o` pulse is high in the cycle after the second clock edge following the mode change. Each pulse lasts exactly one cycle. Later pulses start exactly POLL_US*TICK_CYC cycles apart.
- R5: `det_i` is sampled in the cycle after a request pulse. If it is 1, `term_en_o` rises at the clock edge that follows that cycle and then stays 1. No further requests are issued, and later values of `det_i` have no effect.
- R6: In mode 2'b01, if no receiver is found, exactly WINDOW_POLLS requests are issued and then polling stops for good. `term_en_o` stays 0 even if `det_i` goes high afterwards.
- R7: In mode 2'b10, requests continue past WINDOW_POLLS attempts until a receiver is found.
- R8: While `pdn_i` is 1, `drv_en_o`, `term_en_o` and `det_req_o` are all 0.
- R9: A power-down pulse seen high on fewer than PDN_MIN_US*TICK_CYC clock edges leaves the latched state untouched. After release, `term_en_o` returns to its previous value and no new requests are issued.
- R10: A power-down pulse seen high on at least PDN_MIN_US*TICK_CYC clock edges clears the controller when released. In an automatic mode, `term_en_o` is 0 and a new first request follows two clock edges after the release.
- R11: A change of `mode_i` while `pdn_i` is 0 returns the controller to idle at the next clock edge, dropping a latched termination. The new mode then starts as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Detect mode: 00 manual high impedance, 01 bounded polling, 10 unbounded polling, 11 manual terminated |
| pdn_i | input | 1 | Power-down, active high |
| det_i | input | 1 | Far-end receiver present, from the analog comparator |
| det_req_o | output | 1 | One-cycle request to run a detection test |
| term_en_o | output | 1 | 1 applies the 50-ohm input termination, 0 leaves high impedance |
| drv_en_o | output | 1 | Output driver enable |

## Verification
`drv_en_o` follows `pdn_i` within the same cycle. A mode change or a qualifying power-down release costs one edge to reach idle and a second edge to reach the first request or fixed state. A detection shows on `term_en_o` two edges after the request is seen. The bench drives inputs and samples outputs on the falling edge, then counts exactly these numbers of rising edges before each check, including a check one edge early where that pins the latency. Request counts and the spacing between requests are collected by a monitor on the rising edge, which flags any gap that differs from the poll period. The power-down width is tested one edge below the threshold and exactly at it.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIZ,
    ST_TERM,
    ST_REQ,
    ST_SAMPLE,
    ST_WAIT,
    ST_FOUND,
    ST_GIVEUP
  } rxdet_state_e;

  localparam logic [1:0] MODE_MAN_HIZ  = 2'b00;
  localparam logic [1:0] MODE_AUTO_LIM = 2'b01;
  localparam logic [1:0] MODE_AUTO_INF = 2'b10;
  localparam logic [1:0] MODE_MAN_TERM = 2'b11;

endpackage

// File: rtl/rxdet_poll_timer.sv
// Poll interval counter: reloads when a request issues, flags the
// cycle before the next request is due.
module rxdet_poll_timer #(
  parameter int unsigned PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic reload_i,
  output logic due_o
);

  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)
      cnt_d = CW'(1);
    else if (cnt_q != LAST)
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= cnt_d;
  end

  assign due_o = (cnt_q == LAST);

  // R4: the interval counter never runs past the poll period
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/rxdet_pdn_filter.sv
// Measures the high width of power-down and flags a qualifying release.
module rxdet_pdn_filter #(
  parameter int unsigned MIN_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_i,
  output logic clr_o
);

  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] MINV = CW'(MIN_CYC);

  logic [CW-1:0] wid_q, wid_d;
  logic          pdn_q;

  always_comb begin
    wid_d = '0;
    if (pdn_i)
      wid_d = (wid_q == MINV) ? wid_q : wid_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q <= '0;
      pdn_q <= 1'b0;
    end else begin
      wid_q <= wid_d;
      pdn_q <= pdn_i;
    end
  end

  assign clr_o = pdn_q & ~pdn_i & (wid_q == MINV);

  // R10: a clear is only raised on the cycle power-down drops
  a_r10_clr_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> ($past(pdn_i) && !pdn_i));

endmodule

// File: rtl/rxdet_fsm.sv
// Detect sequencing: fixed modes, polling, latched outcome.
module rxdet_fsm
  import rxdet_pkg::*;
#(
  parameter int unsigned WINDOW = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [1:0]   mode_i,
  input  logic         det_i,
  input  logic         due_i,
  output rxdet_state_e state_o
);

  localparam int unsigned TW = $clog2(WINDOW + 1);
  localparam logic [TW-1:0] LASTT = TW'(WINDOW - 1);
  localparam logic [TW-1:0] MAXT  = TW'(WINDOW);

  rxdet_state_e  state_q, state_d;
  logic [1:0]    mode_q;
  logic [TW-1:0] tries_q, tries_d;

  always_comb begin
    state_d = state_q;
    tries_d = tries_q;
    if (clr_i || (mode_i != mode_q)) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tries_d = '0;
          if (mode_q == MODE_MAN_HIZ)
            state_d = ST_HIZ;
          else if (mode_q == MODE_MAN_TERM)
            state_d = ST_TERM;
          else
            state_d = ST_REQ;
        end
        ST_REQ:    state_d = ST_SAMPLE;
        ST_SAMPLE: begin
          if (det_i)
            state_d = ST_FOUND;
          else if (mode_q == MODE_AUTO_LIM) begin
            if (tries_q == LASTT)
              state_d = ST_GIVEUP;
            else begin
              tries_d = tries_q + TW'(1);
              state_d = ST_WAIT;
            end
          end else
            state_d = ST_WAIT;
        end
        ST_WAIT:   if (due_i) state_d = ST_REQ;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_MAN_HIZ;
      tries_q <= '0;
    end else if (en_i) begin
      state_q <= state_d;
      mode_q  <= mode_i;
      tries_q <= tries_d;
    end
  end

  assign state_o = state_q;

  // R5: a found receiver stays latched until a clear or mode change
  a_r5_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && mode_i == mode_q && state_q == ST_FOUND)
      |=> state_q == ST_FOUND);

  // R6: the bounded mode's terminal state is not left on its own
  a_r6_giveup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && mode_i == mode_q && state_q == ST_GIVEUP)
      |=> state_q == ST_GIVEUP);

  // R6: failed attempts never exceed the window
  a_r6_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < MAXT);

  // R11: an active mode change lands in idle
  a_r11_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && mode_i != mode_q) |=> state_q == ST_IDLE);

endmodule

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
  import rxdet_pkg::*;
#(
  parameter int unsigned TICK_CYC     = 100,
  parameter int unsigned POLL_US      = 12000,
  parameter int unsigned WINDOW_POLLS = 50,
  parameter int unsigned PDN_MIN_US   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       pdn_i,
  input  logic       det_i,
  output logic       det_req_o,
  output logic       term_en_o,
  output logic       drv_en_o
);

  localparam int unsigned POLL_CYC = TICK_CYC * POLL_US;
  localparam int unsigned PDN_CYC  = TICK_CYC * PDN_MIN_US;

  rxdet_state_e state;
  logic         run_en;
  logic         clr;
  logic         due;

  assign run_en = ~pdn_i;

  rxdet_pdn_filter #(.MIN_CYC(PDN_CYC)) u_pdn (
    .clk   (clk),
    .rst_n (rst_n),
    .pdn_i (pdn_i),
    .clr_o (clr)
  );

  rxdet_poll_timer #(.PERIOD(POLL_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (run_en),
    .reload_i (state == ST_REQ),
    .due_o    (due)
  );

  rxdet_fsm #(.WINDOW(WINDOW_POLLS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (run_en),
    .clr_i   (clr),
    .mode_i  (mode_i),
    .det_i   (det_i),
    .due_i   (due),
    .state_o (state)
  );

  assign det_req_o = run_en & (state == ST_REQ);
  assign term_en_o = run_en & ((state == ST_FOUND) | (state == ST_TERM));
  assign drv_en_o  = run_en;

  // R4: a detect request is a single-cycle pulse
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    det_req_o |=> !det_req_o);

  // R8: termination may only drop on power-down, a clear or a mode change
  a_r8_term_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_en_o) |-> (pdn_i || $past(clr) || $past(mode_i) != mode_i
                          || $past(state) == ST_IDLE || state == ST_IDLE));

endmodule

// File: tb/sim_rxdet_ctrl.sv
module sim_rxdet_ctrl;

  localparam int unsigned TICK = 2;
  localparam int unsigned PUS  = 20;
  localparam int unsigned WIN  = 50;
  localparam int unsigned PMIN = 5;
  localparam int POLL_CYC = TICK * PUS;
  localparam int PDN_CYC  = TICK * PMIN;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       pdn;
  logic       det;
  logic       req, term, drv;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  rxdet_ctrl #(
    .TICK_CYC(TICK), .POLL_US(PUS), .WINDOW_POLLS(WIN), .PDN_MIN_US(PMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pdn_i(pdn), .det_i(det),
    .det_req_o(req), .term_en_o(term), .drv_en_o(drv)
  );

  always #10 clk = ~clk;

  // request monitor
  logic mon_arm = 1'b0;
  int   cyc = 0, pulses = 0, gap_bad = 0, last_cyc = 0;
  bit   seen = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!mon_arm) begin
      pulses  <= 0;
      gap_bad <= 0;
      seen    <= 1'b0;
    end else if (req) begin
      pulses <= pulses + 1;
      if (seen && (cyc - last_cyc) != POLL_CYC) gap_bad <= gap_bad + 1;
      last_cyc <= cyc;
      seen     <= 1'b1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // apply a mode: monitor cleared on the restart edge, armed afterwards
  task automatic apply_mode(input logic [1:0] m);
    mode    = m;
    mon_arm = 1'b0;
    step(1);
    mon_arm = 1'b1;
    step(1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pdn = 1'b0; det = 1'b0; mode = 2'b00;
    step(3);
    chk("R1 req in reset", int'(req), 0);
    chk("R1 term in reset", int'(term), 0);
    chk("R1 drv in reset", int'(drv), 1);
    rst_n = 1'b1;
    step(1);
    chk("R1 req after reset", int'(req), 0);
    chk("R1 term after reset", int'(term), 0);
  endtask

  task automatic t_hiz;
    det = 1'b1;
    apply_mode(2'b00);
    step(200);
    chk("R2 no requests", pulses, 0);
    chk("R2 term stays off", int'(term), 0);
    det = 1'b0;
  endtask

  task automatic t_fixed_term;
    mode = 2'b11; mon_arm = 1'b0;
    step(1);
    chk("R3 term one edge early", int'(term), 0);
    mon_arm = 1'b1;
    step(1);
    chk("R3 term on", int'(term), 1);
    det = 1'b1;
    step(200);
    chk("R3 no requests", pulses, 0);
    chk("R3 term held", int'(term), 1);
    det = 1'b0;
  endtask

  task automatic t_bounded;
    det = 1'b0;
    apply_mode(2'b01);
    chk("R4 first request", int'(req), 1);
    step(1);
    chk("R4 single cycle", int'(req), 0);
    step(2100);
    chk("R6 request count", pulses, WIN);
    chk("R4 poll spacing", gap_bad, 0);
    chk("R6 term off", int'(term), 0);
    det = 1'b1;
    step(200);
    chk("R6 no late requests", pulses, WIN);
    chk("R6 late detect ignored", int'(term), 0);
    det = 1'b0;
  endtask

  task automatic t_unbounded;
    int p;
    det = 1'b0;
    apply_mode(2'b10);
    chk("R4 first request inf", int'(req), 1);
    step(2400);
    chk("R7 polls beyond window", int'(pulses > WIN), 1);
    chk("R4 poll spacing inf", gap_bad, 0);
    det = 1'b1;
    for (int i = 0; i < POLL_CYC + 5 && !req; i++) step(1);
    chk("R5 request seen", int'(req), 1);
    chk("R5 term before sample", int'(term), 0);
    step(1);
    chk("R5 term one edge early", int'(term), 0);
    step(1);
    chk("R5 term latched", int'(term), 1);
    p = pulses;
    det = 1'b0;
    step(200);
    chk("R5 term held", int'(term), 1);
    chk("R5 polling stopped", pulses, p);
  endtask

  task automatic t_pdn_short;
    int p;
    p = pulses;
    pdn = 1'b1;
    step(1);
    chk("R8 drv off", int'(drv), 0);
    chk("R8 term off", int'(term), 0);
    chk("R8 req off", int'(req), 0);
    step(PDN_CYC - 2);
    pdn = 1'b0;
    step(2);
    chk("R9 term restored", int'(term), 1);
    chk("R9 drv restored", int'(drv), 1);
    step(100);
    chk("R9 no new requests", pulses, p);
    chk("R9 term still on", int'(term), 1);
  endtask

  task automatic t_pdn_long;
    pdn = 1'b1;
    step(1);
    chk("R8 term off long", int'(term), 0);
    step(PDN_CYC - 1);
    pdn = 1'b0; mon_arm = 1'b0;
    step(1);
    chk("R10 cleared idle term", int'(term), 0);
    chk("R10 no request yet", int'(req), 0);
    mon_arm = 1'b1;
    step(1);
    chk("R10 polling restarted", int'(req), 1);
    step(POLL_CYC + 5);
    chk("R10 second poll", pulses, 2);
    chk("R10 term off", int'(term), 0);
  endtask

  task automatic t_mode_restart;
    step(15);
    mode = 2'b01; mon_arm = 1'b0;
    step(1);
    chk("R11 idle after change", int'(req), 0);
    mon_arm = 1'b1;
    step(1);
    chk("R11 request after change", int'(req), 1);
    det = 1'b1;
    step(2);
    chk("R11 found in new mode", int'(term), 1);
    det = 1'b0;
    mode = 2'b00;
    step(1);
    chk("R11 term dropped", int'(term), 0);
    step(50);
    chk("R11 manual hiz", int'(term), 0);
  endtask

  initial begin
    t_reset();
    t_hiz();
    t_fixed_term();
    t_bounded();
    t_unbounded();
    t_pdn_short();
    t_pdn_long();
    t_mode_restart();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule